// File: doc/BRIEF.md
# Boot Region Address Mapper

The block sits between the processor's boot-region accesses and two memories: a small read-only boot memory and a larger shadow SRAM that covers the whole boot window. Each read in the window goes to exactly one of them. Which one it goes to depends on a one-bit mapping register, the system reset, and whether the access is a vector fetch. Writes into the window always land in the shadow SRAM. This lets boot code copy itself into the SRAM while it still runs from the ROM, and then switch reads over.

The system reset forces reads to the ROM and clears the mapping register. Reads stay on the ROM until software writes the register, and from then on software can move them between the two memories at will. The ROM is smaller than the window, so its address is the low bits of the window address, and ROM contents repeat through the window. Hard reset, soft reset and NMI all fetch from offset zero of the window. A fetch caused by a reset always goes to the ROM, whatever the register holds. An NMI fetch follows the register.

Top module: `bootmap_top`

## Requirements
- R1: When `wrEn` is 1, `sramWrSel` is 1 and `sramWrAddr` equals `wrAddr`, whatever the mapping. When `wrEn` is 0, `sramWrSel` is 0 and `sramWrAddr` is 0.
- R2: While `rstN` is 0, any read (`rdEn` or `vecReq` at 1) sets `romSel`=1 and `sramRdSel`=0, and `mapIsSram` is 0. A `cfgWe` during reset leaves `mapIsSram` at 0 after reset is released.
- R3: After reset is released, plain reads select the ROM until a `cfgWe` with `cfgSram`=1 is taken.
- R4: A `cfgWe` taken at a rising clock edge with `rstN`=1 loads `cfgSram` into the mapping (1 = SRAM, 0 = ROM). The new mapping steers reads, and shows on `mapIsSram`, from that edge onward. Without `cfgWe` the mapping holds, and it can be switched back and forth any number of times.
- R5: A plain read that selects the ROM drives `romAddr` = `rdAddr` modulo 2^ROM_AW, that is, its low ROM_AW bits. A read that selects the SRAM drives `sramRdAddr` = `rdAddr`.
- R6: `vecAddr` is always 0. A vector fetch (`vecReq`=1) ignores `rdAddr` and drives address 0 to the memory it selects.
- R7: A reset vector fetch (`vecReq`=1, `vecIsNmi`=0) selects the ROM even when the mapping is SRAM.
- R8: An NMI vector fetch (`vecReq`=1, `vecIsNmi`=1) follows the mapping, as a plain read does.
- R9: With no read request, `romSel` and `sramRdSel` are both 0 and both read addresses are 0. At most one read select is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset, asynchronous |
| rdEn | input | 1 | Plain read request in the boot window |
| rdAddr | input | WIN_AW | Read offset within the window |
| wrEn | input | 1 | Write request in the boot window |
| wrAddr | input | WIN_AW | Write offset within the window |
| cfgWe | input | 1 | Mapping register write strobe |
| cfgSram | input | 1 | Mapping value to load (1 = SRAM) |
| vecReq | input | 1 | Vector fetch request |
| vecIsNmi | input | 1 | Vector fetch cause: 1 = NMI, 0 = reset |
| romSel | output | 1 | ROM read select |
| romAddr | output | ROM_AW | ROM read address (aliased) |
| sramRdSel | output | 1 | SRAM read select |
| sramRdAddr | output | WIN_AW | SRAM read address |
| sramWrSel | output | 1 | SRAM write select |
| sramWrAddr | output | WIN_AW | SRAM write address |
| mapIsSram | output | 1 | Readback of the mapping register |
| vecAddr | output | WIN_AW | Fixed fetch vector (window start) |

## Verification
The hardest case to reach is a reset-cause vector fetch while the mapping register already points at the SRAM. Any real reset clears the register, so this only happens when a vector request arrives after software has switched the mapping. The directed sequence first takes a mapping write, then issues a reset-kind vector fetch and checks that it lands on ROM address zero. Right after that it issues an NMI-kind fetch and checks that it goes to the SRAM. The random phase mixes mapping writes, vector requests of both kinds and short reset pulses, so this case recurs many times.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic rdRom;   // read goes to ROM
    logic rdSram;  // read goes to SRAM
    logic wrSram;  // write goes to SRAM
    logic useVec;  // read address replaced by the vector
  } mapStrobe_t;
endpackage

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
  import bootmap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       cfgWe,
  input  logic       cfgSram,
  input  logic       vecReq,
  input  logic       vecIsNmi,
  output mapStrobe_t strobe,
  output logic       mapIsSram
);
  logic mapReg;
  logic rdActive;
  logic forceRom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      mapReg <= 1'b0;
    else if (cfgWe) mapReg <= cfgSram;
  end

  always_comb begin
    rdActive      = rdEn | vecReq;
    forceRom      = !rstN | (vecReq & !vecIsNmi) | !mapReg;
    strobe.rdRom  = rdActive & forceRom;
    strobe.rdSram = rdActive & !forceRom;
    strobe.wrSram = wrEn;
    strobe.useVec = vecReq;
  end

  assign mapIsSram = mapReg;

  // R2
  always_ff @(posedge clk) begin
    if (!rstN && rdActive)
      reset_rom_chk: assert (strobe.rdRom && !strobe.rdSram && !mapIsSram);
  end

  // R4
  map_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (mapIsSram == $past(cfgSram)));

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(mapIsSram));
endmodule

// File: rtl/bootmap_dp.sv
module bootmap_dp
  import bootmap_pkg::*;
#(
  parameter int WIN_AW = 12,
  parameter int ROM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [WIN_AW-1:0] rdAddr,
  input  logic [WIN_AW-1:0] wrAddr,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic              sramRdSel,
  output logic [WIN_AW-1:0] sramRdAddr,
  output logic              sramWrSel,
  output logic [WIN_AW-1:0] sramWrAddr,
  output logic [WIN_AW-1:0] vecAddr
);
  localparam logic [WIN_AW-1:0] VecBase = '0;
  logic [WIN_AW-1:0] effAddr;
  logic [ROM_AW-1:0] aliasAddr;

  assign effAddr = strobe.useVec ? VecBase : rdAddr;

  generate
    if (ROM_AW < WIN_AW) begin : g_alias
      assign aliasAddr = effAddr[ROM_AW-1:0];
    end else begin : g_full
      assign aliasAddr = effAddr;
    end
  endgenerate

  assign romSel     = strobe.rdRom;
  assign romAddr    = strobe.rdRom  ? aliasAddr : '0;
  assign sramRdSel  = strobe.rdSram;
  assign sramRdAddr = strobe.rdSram ? effAddr : '0;
  assign sramWrSel  = strobe.wrSram;
  assign sramWrAddr = strobe.wrSram ? wrAddr : '0;
  assign vecAddr    = VecBase;

  // R5
  rom_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdRom && !strobe.useVec) |-> (romAddr == rdAddr[ROM_AW-1:0]));
endmodule

// File: rtl/bootmap_top.sv
module bootmap_top
  import bootmap_pkg::*;
#(
  parameter int WIN_AW = 12,
  parameter int ROM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [WIN_AW-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [WIN_AW-1:0] wrAddr,
  input  logic              cfgWe,
  input  logic              cfgSram,
  input  logic              vecReq,
  input  logic              vecIsNmi,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic              sramRdSel,
  output logic [WIN_AW-1:0] sramRdAddr,
  output logic              sramWrSel,
  output logic [WIN_AW-1:0] sramWrAddr,
  output logic              mapIsSram,
  output logic [WIN_AW-1:0] vecAddr
);
  mapStrobe_t strobe;

  bootmap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .cfgWe(cfgWe),
    .cfgSram(cfgSram), .vecReq(vecReq), .vecIsNmi(vecIsNmi),
    .strobe(strobe), .mapIsSram(mapIsSram)
  );

  bootmap_dp #(.WIN_AW(WIN_AW), .ROM_AW(ROM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .romSel(romSel), .romAddr(romAddr), .sramRdSel(sramRdSel),
    .sramRdAddr(sramRdAddr), .sramWrSel(sramWrSel), .sramWrAddr(sramWrAddr),
    .vecAddr(vecAddr)
  );

  // R1
  write_to_sram_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (sramWrSel && sramWrAddr == wrAddr));

  // R7
  reset_vec_rom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !vecIsNmi) |-> (romSel && !sramRdSel && romAddr == '0));

  // R6
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (romAddr == '0 && sramRdAddr == '0));

  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, sramRdSel}));
endmodule

// File: tb/sim_bootmap_top.sv
module sim_bootmap_top;
  localparam int WIN_AW = 12;
  localparam int ROM_AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 0, wrEn = 0, cfgWe = 0, cfgSram = 0, vecReq = 0, vecIsNmi = 0;
  logic [WIN_AW-1:0] rdAddr = '0, wrAddr = '0;
  logic romSel, sramRdSel, sramWrSel, mapIsSram;
  logic [ROM_AW-1:0] romAddr;
  logic [WIN_AW-1:0] sramRdAddr, sramWrAddr, vecAddr;

  int nChecks = 0;
  int nFails = 0;
  logic expMap = 1'b0;
  bit done = 0;

  always #5ns clk = ~clk;

  bootmap_top #(.WIN_AW(WIN_AW), .ROM_AW(ROM_AW)) u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .cfgWe(cfgWe), .cfgSram(cfgSram), .vecReq(vecReq),
    .vecIsNmi(vecIsNmi), .romSel(romSel), .romAddr(romAddr),
    .sramRdSel(sramRdSel), .sramRdAddr(sramRdAddr), .sramWrSel(sramWrSel),
    .sramWrAddr(sramWrAddr), .mapIsSram(mapIsSram), .vecAddr(vecAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expToRom();
    return (rdEn | vecReq) & (!rstN | (vecReq & !vecIsNmi) | !expMap);
  endfunction

  function automatic logic [WIN_AW-1:0] expEff();
    return vecReq ? '0 : rdAddr;
  endfunction

  // Compare every output with the model
  task automatic checkAll(input string req);
    logic toRom, toSram;
    logic [WIN_AW-1:0] eff;
    #1;
    toRom  = expToRom();
    toSram = (rdEn | vecReq) & !toRom;
    eff    = expEff();
    chk(req, "romSel", 32'(romSel), 32'(toRom));
    chk(req, "sramRdSel", 32'(sramRdSel), 32'(toSram));
    chk(req, "romAddr", 32'(romAddr), toRom ? 32'(eff[ROM_AW-1:0]) : 32'd0);
    chk(req, "sramRdAddr", 32'(sramRdAddr), toSram ? 32'(eff) : 32'd0);
    chk("R1", "sramWrSel", 32'(sramWrSel), 32'(wrEn));
    chk("R1", "sramWrAddr", 32'(sramWrAddr), wrEn ? 32'(wrAddr) : 32'd0);
    chk(req, "mapIsSram", 32'(mapIsSram), 32'(expMap));
    chk("R6", "vecAddr", 32'(vecAddr), 32'd0);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rstN && cfgWe) expMap = cfgSram;
    @(negedge clk);
  endtask

  task automatic idle();
    rdEn = 0; wrEn = 0; cfgWe = 0; vecReq = 0; vecIsNmi = 0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    string tag;
    void'($urandom(32'd2024));
    @(negedge clk);
    // Reset state, read at top of window aliases (R2, R5)
    rdEn = 1; rdAddr = 12'hFFF;
    checkAll("R2");
    chk("R5", "romAddr alias", 32'(romAddr), 32'h3FF);
    // cfg write during reset is ignored (R2)
    cfgWe = 1; cfgSram = 1;
    tick();
    idle();
    rstN = 1;
    tick();
    chk("R2", "map after reset-time cfgWe", 32'(mapIsSram), 32'd0);
    // Reads stay on ROM (R3)
    rdEn = 1; rdAddr = 12'h405;
    checkAll("R3");
    chk("R3", "romSel after reset", 32'(romSel), 32'd1);
    tick();
    // Switch: same cycle still ROM, next cycle SRAM (R4)
    cfgWe = 1; cfgSram = 1; rdAddr = 12'h812;
    checkAll("R4");
    chk("R4", "romSel in write cycle", 32'(romSel), 32'd1);
    tick();
    cfgWe = 0;
    checkAll("R4");
    chk("R4", "sramRdSel after switch", 32'(sramRdSel), 32'd1);
    chk("R5", "sramRdAddr full", 32'(sramRdAddr), 32'h812);
    // Reset vector while mapped to SRAM (R7)
    rdEn = 0; vecReq = 1; vecIsNmi = 0; rdAddr = 12'hABC;
    checkAll("R7");
    chk("R7", "reset vector romSel", 32'(romSel), 32'd1);
    chk("R6", "reset vector addr", 32'(romAddr), 32'd0);
    // NMI vector follows mapping (R8)
    vecIsNmi = 1;
    checkAll("R8");
    chk("R8", "nmi vector sramRdSel", 32'(sramRdSel), 32'd1);
    // Write while SRAM mapped, no read (R1, R9)
    idle(); wrEn = 1; wrAddr = 12'h3C3;
    checkAll("R9");
    chk("R9", "no read romSel", 32'(romSel), 32'd0);
    tick();
    // Back to ROM, then write still to SRAM (R4, R1)
    idle(); cfgWe = 1; cfgSram = 0;
    tick();
    idle(); wrEn = 1; wrAddr = 12'hF00; rdEn = 1; rdAddr = 12'h7FF;
    checkAll("R1");
    chk("R4", "back on ROM", 32'(romSel), 32'd1);
    tick();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if (!rstN) rstN = ($urandom_range(0, 2) != 0);
      else if ($urandom_range(0, 60) == 0) begin rstN = 0; expMap = 0; end
      rdEn     = $urandom_range(0, 3) != 0;
      rdAddr   = WIN_AW'($urandom);
      wrEn     = $urandom_range(0, 1);
      wrAddr   = WIN_AW'($urandom);
      cfgWe    = $urandom_range(0, 4) == 0;
      cfgSram  = $urandom_range(0, 1);
      vecReq   = $urandom_range(0, 5) == 0;
      vecIsNmi = $urandom_range(0, 1);
      if (!rstN) tag = "R2";
      else if (vecReq) tag = vecIsNmi ? "R8" : "R7";
      else if (rdEn) tag = expMap ? "R4" : "R3";
      else tag = "R9";
      checkAll(tag);
      tick();
    end
    done = 1;
    finishRun();
  end
endmodule